// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides its input clock by a programmable integer from 1 to 6. It produces a divided waveform and a one-cycle strobe that marks the first input cycle of every output period. Several copies that receive the same external sync pulse restart their periods on the same input edge, so their output phases line up.

A single control register sets the ratio and the sync policy. The sync input may be ignored, honoured on every pulse, or honoured once per register write. In the once-per-write mode the block is armed by the write and exposes that armed state on a port. The sync pin is asynchronous and is resynchronized inside the block. A new ratio is held pending until the current period ends, so a period is never cut short by a ratio change.

Top module: `cdiv_top`

## Requirements
- R1: While `rst_n` is low, `div_out`, `phase0` and `oneshot_armed` are 0. The reset configuration is ratio 1 with sync handling off.
- R2: With an active ratio N, `phase0` is high for exactly one input cycle every N cycles, and `div_out` is high in that cycle.
- R3: In each period, `div_out` is high for the first (N+1)/2 cycles and low for the remaining cycles. With ratio 1, `div_out` stays high.
- R4: A write takes effect only when `wr_en` is high and `wr_addr` equals `CTRL_ADDR` (default 0x100). In the written data, bit 1 enables sync handling, bit 2 selects the once-per-write mode (1) or the every-pulse mode (0), and bits [6:4] hold the ratio. Writes to any other address change nothing.
- R5: A written ratio of 0 is used as 1, and a written ratio of 7 is used as 6.
- R6: A new ratio is loaded only at the end of the current period. The period that is running when the write lands completes at its old length.
- R7: A rising edge on `sync_in` passes through two synchronizing flops. When accepted, it makes `phase0` high in the cycle after the third rising clock edge that follows the pin change. The count restarts from phase zero at that point, and any pending ratio is loaded.
- R8: When bit 1 is clear, sync edges are ignored and the running period is undisturbed.
- R9: In the every-pulse mode, each sync rising edge is accepted.
- R10: A write with bits 1 and 2 both set raises `oneshot_armed`. The first sync edge after that write is accepted and clears `oneshot_armed`. Further edges are ignored until the next such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low reset, synchronous to clk_in |
| sync_in | input | 1 | Asynchronous alignment pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| div_out | output | 1 | Divided clock waveform |
| phase0 | output | 1 | One-cycle marker for the first cycle of each output period |
| oneshot_armed | output | 1 | Once-per-write sync mode is armed |

## Verification
A corrupted count or a wrong active ratio shows up at the next `phase0`: the strobe arrives early or late, or the high time of `div_out` no longer matches (N+1)/2. Either can be seen within one output period of six cycles or fewer. A wrong sync decision, accepting or rejecting, is visible on the third edge after the pin changes: `phase0` is present or absent there, against a free-running phase whose position is known. A stale armed flag appears at once on `oneshot_armed`. It also shows on the second sync edge, which must leave the period untouched.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
    localparam int RATIO_W     = 3;
    localparam int RATIO_MAX   = 6;
    localparam int BIT_EN      = 1;
    localparam int BIT_ONESHOT = 2;
    localparam int RATIO_LSB   = 4;

    typedef logic [RATIO_W-1:0] ratio_t;

    localparam ratio_t RATIO_TOP = ratio_t'(RATIO_MAX);
    localparam ratio_t RATIO_ONE = ratio_t'(1);

    typedef struct packed {
        ratio_t ratio;
        logic   en;
        logic   oneshot;
        logic   armed;
    } ctrl_t;

    typedef struct packed {
        ratio_t cnt;
        ratio_t act;
        logic   wave;
        logic   ph0;
    } core_t;

    function automatic ratio_t clamp_ratio(input ratio_t r);
        if (r == '0)
            return RATIO_ONE;
        if (r > RATIO_TOP)
            return RATIO_TOP;
        return r;
    endfunction
endpackage

// File: rtl/cdiv_sync_in.sv
`timescale 1ns/1ps
module cdiv_sync_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    // STAGES synchronizing flops plus one flop for edge detection
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/cdiv_ctrl.sv
`timescale 1ns/1ps
module cdiv_ctrl
    import cdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_hit,
    input  logic   wr_en_bit,
    input  logic   wr_oneshot_bit,
    input  ratio_t wr_ratio,
    input  logic   sync_rise,
    output ratio_t pend_ratio,
    output logic   accept,
    output logic   armed
);
    ctrl_t ctl_d, ctl_q;
    logic  accept_c;

    always_comb begin
        ctl_d    = ctl_q;
        accept_c = sync_rise & ctl_q.en & (~ctl_q.oneshot | ctl_q.armed);
        if (accept_c)
            ctl_d.armed = 1'b0;
        // a write wins over a same-cycle accept and re-arms
        if (wr_hit) begin
            ctl_d.ratio   = clamp_ratio(wr_ratio);
            ctl_d.en      = wr_en_bit;
            ctl_d.oneshot = wr_oneshot_bit;
            ctl_d.armed   = wr_en_bit & wr_oneshot_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.ratio   <= RATIO_ONE;
            ctl_q.en      <= 1'b0;
            ctl_q.oneshot <= 1'b0;
            ctl_q.armed   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pend_ratio = ctl_q.ratio;
    assign accept     = accept_c;
    assign armed      = ctl_q.armed;
endmodule

// File: rtl/cdiv_core.sv
`timescale 1ns/1ps
module cdiv_core
    import cdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   restart,
    input  ratio_t pend_ratio,
    output logic   wave,
    output logic   ph0,
    output ratio_t act_ratio
);
    core_t            st_d, st_q;
    logic [RATIO_W:0] half_sum;

    always_comb begin
        st_d = st_q;
        if (restart || st_q.cnt == st_q.act - 1'b1) begin
            st_d.cnt = '0;
            st_d.act = pend_ratio;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // high for ceil(N/2) cycles of each period
        half_sum = {1'b0, st_d.act} + 1'b1;
        st_d.wave = (st_d.cnt < half_sum[RATIO_W:1]);
        st_d.ph0  = (st_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.act  <= RATIO_ONE;
            st_q.wave <= 1'b0;
            st_q.ph0  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave      = st_q.wave;
    assign ph0       = st_q.ph0;
    assign act_ratio = st_q.act;
endmodule

// File: rtl/cdiv_top.sv
`timescale 1ns/1ps
module cdiv_top
    import cdiv_pkg::*;
#(
    parameter int               ADDR_W      = 12,
    parameter int               DATA_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 12'h100,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              div_out,
    output logic              phase0,
    output logic              oneshot_armed
);
    logic   ctrl_wr;
    logic   sync_rise;
    logic   hit;
    ratio_t pend_ratio;
    ratio_t act_ratio;
    logic   unused_wr_bits;

    assign ctrl_wr        = wr_en && (wr_addr == CTRL_ADDR);
    assign unused_wr_bits = ^wr_data;

    cdiv_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk_in),
        .rst_n(rst_n),
        .pin  (sync_in),
        .rise (sync_rise)
    );

    cdiv_ctrl u_ctrl (
        .clk           (clk_in),
        .rst_n         (rst_n),
        .wr_hit        (ctrl_wr),
        .wr_en_bit     (wr_data[BIT_EN]),
        .wr_oneshot_bit(wr_data[BIT_ONESHOT]),
        .wr_ratio      (wr_data[RATIO_LSB +: RATIO_W]),
        .sync_rise     (sync_rise),
        .pend_ratio    (pend_ratio),
        .accept        (hit),
        .armed         (oneshot_armed)
    );

    cdiv_core u_core (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .restart   (hit),
        .pend_ratio(pend_ratio),
        .wave      (div_out),
        .ph0       (phase0),
        .act_ratio (act_ratio)
    );
endmodule

// File: rtl/cdiv_chk.sv
`timescale 1ns/1ps
module cdiv_chk
    import cdiv_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   hit,
    input logic   ctrl_wr,
    input logic   phase0,
    input logic   div_out,
    input logic   armed,
    input ratio_t act
);
    logic             hit_q, seen_q;
    logic [3:0]       gap_q;
    ratio_t           per_q;
    logic [RATIO_W:0] half_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            seen_q <= 1'b0;
            gap_q  <= '0;
            per_q  <= RATIO_ONE;
        end else begin
            hit_q <= hit;
            if (phase0) begin
                gap_q  <= 4'd1;
                per_q  <= act;
                seen_q <= 1'b1;
            end else if (gap_q != 4'hF) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assign half_w = ({1'b0, per_q} + 1'b1) >> 1;

    // R2
    ph0_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase0 |-> div_out);

    // R2
    period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && phase0 && !hit_q) |-> (gap_q == {1'b0, per_q}));

    // R3
    high_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $fell(div_out)) |-> (gap_q == {1'b0, half_w}));

    // R7
    sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> phase0);

    // R10
    armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && hit && !ctrl_wr) |=> !armed);
endmodule

bind cdiv_top cdiv_chk u_chk (
    .clk    (clk_in),
    .rst_n  (rst_n),
    .hit    (hit),
    .ctrl_wr(ctrl_wr),
    .phase0 (phase0),
    .div_out(div_out),
    .armed  (oneshot_armed),
    .act    (act_ratio)
);

// File: tb/sim_cdiv_top.sv
`timescale 1ns/1ps
module sim_cdiv_top;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic        sync_in = 1'b0;
    logic        wr_en  = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        div_out, phase0, oneshot_armed;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    localparam logic [11:0] CADDR = 12'h100;
    localparam logic [7:0]  EN = 8'h02;
    localparam logic [7:0]  OS = 8'h04;

    always #2 clk_in = ~clk_in;

    cdiv_top u0 (
        .clk_in(clk_in), .rst_n(rst_n), .sync_in(sync_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .div_out(div_out), .phase0(phase0), .oneshot_armed(oneshot_armed)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk_in);
        wr_en = 1'b0;
    endtask

    task automatic to_ph0(output int c);
        c = 0;
        do begin
            @(negedge clk_in);
            c++;
        end while (!phase0 && c < 40);
    endtask

    task automatic measure(input int n);
        int c;
        to_ph0(c);
        to_ph0(c);
        for (int k = 0; k < n; k++) begin
            chk("R3 div_out level", int'(div_out), int'(k < (n + 1) / 2));
            chk("R2 phase0 only at start", int'(phase0), int'(k == 0));
            @(negedge clk_in);
        end
        chk("R2 phase0 after N cycles", int'(phase0), 1);
    endtask

    // called on a phase0 sample; returns phase0 and armed three edges later
    task automatic sync_try(output int ph, output int arm);
        sync_in = 1'b1;
        repeat (3) @(negedge clk_in);
        ph  = int'(phase0);
        arm = int'(oneshot_armed);
        sync_in = 1'b0;
        repeat (4) @(negedge clk_in);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk_in);
        chk("R1 div_out in reset", int'(div_out), 0);
        chk("R1 phase0 in reset", int'(phase0), 0);
        chk("R1 armed in reset", int'(oneshot_armed), 0);
        rst_n = 1'b1;
        @(negedge clk_in);
        for (int k = 0; k < 6; k++) begin
            chk("R1 R2 default ratio 1 phase0", int'(phase0), 1);
            chk("R3 ratio 1 div_out high", int'(div_out), 1);
            @(negedge clk_in);
        end
    endtask

    task automatic t_ratios;
        for (int n = 1; n <= 6; n++) begin
            wr(CADDR, 8'(n << 4));
            measure(n);
        end
    endtask

    task automatic t_change;
        int c;
        wr(CADDR, 8'(3 << 4));
        measure(3);
        wr(CADDR, 8'(5 << 4));
        to_ph0(c);
        chk("R6 old period completes", c + 1, 3);
        to_ph0(c);
        chk("R6 new ratio after boundary", c, 5);
    endtask

    task automatic t_addr;
        int c;
        wr(12'h101, 8'(2 << 4));
        to_ph0(c);
        to_ph0(c);
        chk("R4 other address ignored", c, 5);
        wr(12'h000, 8'(2 << 4));
        to_ph0(c);
        to_ph0(c);
        chk("R4 address 0 ignored", c, 5);
    endtask

    task automatic t_sat;
        int c;
        wr(CADDR, 8'h00);
        to_ph0(c);
        to_ph0(c);
        chk("R5 ratio 0 used as 1", c, 1);
        wr(CADDR, 8'(7 << 4));
        to_ph0(c);
        to_ph0(c);
        chk("R5 ratio 7 used as 6", c, 6);
    endtask

    task automatic t_sync_off;
        int c, ph, arm;
        wr(CADDR, 8'(6 << 4));
        to_ph0(c);
        to_ph0(c);
        sync_try(ph, arm);
        chk("R8 sync ignored when disabled", ph, 0);
        to_ph0(c);
        chk("R8 period undisturbed", c, 5);
    endtask

    task automatic t_sync_every;
        int c, ph, arm;
        wr(CADDR, 8'(6 << 4) | EN);
        to_ph0(c);
        to_ph0(c);
        sync_try(ph, arm);
        chk("R7 R9 first sync restarts phase", ph, 1);
        to_ph0(c);
        chk("R7 count restarted at sync", c, 2);
        sync_try(ph, arm);
        chk("R9 second sync also accepted", ph, 1);
        chk("R9 armed stays low", arm, 0);
    endtask

    task automatic t_oneshot;
        int c, ph, arm;
        wr(CADDR, 8'(6 << 4) | EN | OS);
        chk("R10 write arms", int'(oneshot_armed), 1);
        to_ph0(c);
        to_ph0(c);
        sync_try(ph, arm);
        chk("R10 first sync accepted", ph, 1);
        chk("R10 armed cleared", arm, 0);
        to_ph0(c);
        sync_try(ph, arm);
        chk("R10 second sync ignored", ph, 0);
        to_ph0(c);
        chk("R10 period undisturbed", c, 5);
        wr(CADDR, 8'(6 << 4) | EN | OS);
        chk("R10 rewrite re-arms", int'(oneshot_armed), 1);
        to_ph0(c);
        sync_try(ph, arm);
        chk("R10 sync after re-arm accepted", ph, 1);
    endtask

    initial begin
        t_reset();
        t_ratios();
        t_change();
        t_addr();
        t_sat();
        t_sync_off();
        t_sync_every();
        t_oneshot();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule